// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register storage of a 32-bit processor with seven operating modes. Software sees sixteen registers, r0 to r15. Some of these registers have private copies for certain modes. r13 and r14 have a separate copy for each exception mode, with user and system modes sharing one copy. r8 to r12 have an extra copy that only the fast-interrupt mode uses. The five exception modes each also keep a saved status word. The block holds the current status word. The mode field in bits 4:0 of that word selects which copies the read and write ports reach.

The pipeline reads operands through two combinational read ports and writes results through one write port. Each of these ports sees the register view of the current mode. Privileged instructions that move data to or from user registers use a separate user-bank port. That port always reaches the copies that user and system modes use. Exception entry and return use the status-word write port and the saved-status write port.

The storage is indexed directly by mode. A mode change therefore costs no extra cycles: the new status word is registered, and from the next cycle on every port reaches the new mode's copies.

Top module: `bankedRegFile`

## Requirements
- R1: While reset is low, and afterwards until the first write, the status word reads 0x0000001F (system mode) and modeErr is 0. Every register, every banked copy and every saved status word reads 0.
- R2: r0 to r7 and r15 have a single copy. A value written to one of them in any mode reads back unchanged in every mode.
- R3: r13 and r14 each have six copies: one shared by user (10000) and system (11111), and one each for supervisor (10011), abort (10111), undefined (11011), interrupt (10010) and fast-interrupt (10001).
- R4: r8 to r12 each have two copies: one for fast-interrupt mode, and one shared by all other modes.
- R5: A status write whose bits 4:0 hold one of the seven mode encodings stores the whole 32-bit word at the clock edge. From the next cycle the ports use the banks of the new mode. A write that keeps the same mode changes only the other bits.
- R6: A status write whose bits 4:0 hold any other encoding is discarded: the status word and the bank mapping stay as they were. modeErr is 1 for exactly the following cycle.
- R7: savedPsr shows the saved status copy of the active exception mode. Each of the five exception modes keeps its own copy. In user or system mode a saved-status write has no effect, and savedPsr equals the current status word.
- R8: The user-bank port (read and write) reaches the non-fast-interrupt copy for indices 8 to 12, and the user/system copy for indices 13 and 14. For all other indices it reaches the same single register as the normal ports.
- R9: If the normal write port and the user-bank write port hit the same storage at one edge, the normal write port's value is kept. If they hit different copies, both values are stored.
- R10: Reads are combinational and have no bypass: a write becomes visible in the cycle after its edge. Register writes and saved-status writes that arrive at the same edge as a status write use the mode that was in force before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 4 | Read port A register index |
| rdDataA | output | 32 | Read port A data, current mode view |
| rdAddrB | input | 4 | Read port B register index |
| rdDataB | output | 32 | Read port B data, current mode view |
| wrEn | input | 1 | Normal write enable |
| wrAddr | input | 4 | Normal write register index |
| wrData | input | 32 | Normal write data |
| userWe | input | 1 | User-bank port write enable |
| userAddr | input | 4 | User-bank port register index |
| userWrData | input | 32 | User-bank port write data |
| userRdData | output | 32 | User-bank port read data |
| savedWrEn | input | 1 | Saved status write enable |
| savedWrData | input | 32 | Saved status write data |
| savedPsr | output | 32 | Saved status of active mode (status word in user/system) |
| psrWrEn | input | 1 | Status word write enable |
| psrWrData | input | 32 | Status word write data |
| psr | output | 32 | Current status word |
| modeErr | output | 1 | One-cycle pulse after a status write with an illegal mode |

## Verification
The hardest case to reach from the ports is a register value that stays put while the mode moves through several other banks. An example is a supervisor r13 value written early, which must come back after passes through fast-interrupt, user and abort modes, with writes in each of them. The stimulus first fills every copy with a value that encodes its mode and index. It then steps through all seven modes, sweeping every index on both read ports and on the user-bank port. After that comes a long random phase. In this phase, status, saved-status, normal and user-bank writes land at the same edge, and an illegal mode encoding appears now and then. All results are compared every cycle against a reference model in the bench that swaps copies on each mode change.

// File: rtl/bankRfPkg.sv
package bankRfPkg;

  localparam int MODE_W    = 5;
  localparam int NUM_BANKS = 6;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } cpuMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [BANK_W-1:0] bank;      // 0 = user/system, 5 = fast interrupt
    logic              fiqSel;
    logic              hasSaved;
    logic              gprWe;
    logic              userWe;
    logic              savedWe;
  } rfStrobe_t;

  function automatic logic modeValid(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] bankOf(input logic [MODE_W-1:0] m);
    case (m)
      MODE_SVC: return BANK_W'(1);
      MODE_ABT: return BANK_W'(2);
      MODE_UND: return BANK_W'(3);
      MODE_IRQ: return BANK_W'(4);
      MODE_FIQ: return BANK_W'(5);
      default:  return BANK_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/bankRfCtrl.sv
module bankRfCtrl
  import bankRfPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psrWrEn,
  input  logic [DATA_W-1:0] psrWrData,
  input  logic              wrEn,
  input  logic              userWe,
  input  logic              savedWrEn,
  output logic [DATA_W-1:0] psr,
  output logic              modeErr,
  output rfStrobe_t         strobe
);

  localparam logic [DATA_W-1:0] RESET_PSR = DATA_W'(32'h0000_001F);

  logic [MODE_W-1:0] curMode;
  logic              newLegal;

  assign curMode  = psr[MODE_W-1:0];
  assign newLegal = modeValid(psrWrData[MODE_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psr     <= RESET_PSR;
      modeErr <= 1'b0;
    end else begin
      modeErr <= psrWrEn && !newLegal;
      if (psrWrEn && newLegal) psr <= psrWrData;
    end
  end

  always_comb begin
    strobe.bank     = bankOf(curMode);
    strobe.fiqSel   = (curMode == MODE_FIQ);
    strobe.hasSaved = (strobe.bank != '0);
    strobe.gprWe    = wrEn;
    strobe.userWe   = userWe;
    strobe.savedWe  = savedWrEn && strobe.hasSaved;
  end

endmodule

// File: rtl/bankRfData.sv
module bankRfData
  import bankRfPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rfStrobe_t                   strobe,
  input  logic [$clog2(NUM_REGS)-1:0] rdAddrA,
  input  logic [$clog2(NUM_REGS)-1:0] rdAddrB,
  input  logic [$clog2(NUM_REGS)-1:0] wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [$clog2(NUM_REGS)-1:0] userAddr,
  input  logic [DATA_W-1:0]           userWrData,
  input  logic [DATA_W-1:0]           savedWrData,
  input  logic [DATA_W-1:0]           psrIn,
  output logic [DATA_W-1:0]           rdDataA,
  output logic [DATA_W-1:0]           rdDataB,
  output logic [DATA_W-1:0]           userRdData,
  output logic [DATA_W-1:0]           savedPsr
);

  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int HI_CNT    = 5;
  localparam int HI_W      = $clog2(HI_CNT);
  localparam int NUM_WPORT = 2;   // 0 = user-bank port, 1 = normal port (wins)
  localparam logic [IDX_W-1:0] FIRST_HI = IDX_W'(8);
  localparam logic [IDX_W-1:0] LAST_HI  = IDX_W'(12);
  localparam logic [IDX_W-1:0] SP_IDX   = IDX_W'(13);
  localparam logic [IDX_W-1:0] LR_IDX   = IDX_W'(14);

  // Shared copies: r0-r15 with r8-r12 non-fiq and r13/r14 user/system
  logic [DATA_W-1:0] liveRegs  [NUM_REGS];
  logic [DATA_W-1:0] fiqHi     [HI_CNT];
  logic [DATA_W-1:0] spBank    [1:NUM_BANKS-1];
  logic [DATA_W-1:0] lrBank    [1:NUM_BANKS-1];
  logic [DATA_W-1:0] savedRegs [1:NUM_BANKS-1];

  function automatic logic isHi(input logic [IDX_W-1:0] a);
    return (a >= FIRST_HI) && (a <= LAST_HI);
  endfunction

  function automatic logic [HI_W-1:0] hiOff(input logic [IDX_W-1:0] a);
    return HI_W'(a - FIRST_HI);
  endfunction

  function automatic logic [DATA_W-1:0] readPhys(input logic [IDX_W-1:0]  a,
                                                 input logic [BANK_W-1:0] b,
                                                 input logic              f);
    if (f && isHi(a))                 return fiqHi[hiOff(a)];
    else if (a == SP_IDX && b != '0)  return spBank[b];
    else if (a == LR_IDX && b != '0)  return lrBank[b];
    else                              return liveRegs[a];
  endfunction

  assign rdDataA    = readPhys(rdAddrA, strobe.bank, strobe.fiqSel);
  assign rdDataB    = readPhys(rdAddrB, strobe.bank, strobe.fiqSel);
  assign userRdData = readPhys(userAddr, '0, 1'b0);
  assign savedPsr   = strobe.hasSaved ? savedRegs[strobe.bank] : psrIn;

  logic              pWe   [NUM_WPORT];
  logic [IDX_W-1:0]  pAddr [NUM_WPORT];
  logic [DATA_W-1:0] pData [NUM_WPORT];
  logic [BANK_W-1:0] pBank [NUM_WPORT];
  logic              pFiq  [NUM_WPORT];

  always_comb begin
    pWe[0] = strobe.userWe; pAddr[0] = userAddr; pData[0] = userWrData;
    pBank[0] = '0;          pFiq[0] = 1'b0;
    pWe[1] = strobe.gprWe;  pAddr[1] = wrAddr;   pData[1] = wrData;
    pBank[1] = strobe.bank; pFiq[1] = strobe.fiqSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) liveRegs[i] <= '0;
      for (int i = 0; i < HI_CNT; i++)   fiqHi[i]    <= '0;
      for (int i = 1; i < NUM_BANKS; i++) begin
        spBank[i]    <= '0;
        lrBank[i]    <= '0;
        savedRegs[i] <= '0;
      end
    end else begin
      for (int p = 0; p < NUM_WPORT; p++) begin
        if (pWe[p]) begin
          if (pFiq[p] && isHi(pAddr[p]))                fiqHi[hiOff(pAddr[p])] <= pData[p];
          else if (pAddr[p] == SP_IDX && pBank[p] != '0) spBank[pBank[p]]       <= pData[p];
          else if (pAddr[p] == LR_IDX && pBank[p] != '0) lrBank[pBank[p]]       <= pData[p];
          else                                           liveRegs[pAddr[p]]     <= pData[p];
        end
      end
      if (strobe.savedWe) savedRegs[strobe.bank] <= savedWrData;
    end
  end

endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import bankRfPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [$clog2(NUM_REGS)-1:0] rdAddrA,
  output logic [DATA_W-1:0]           rdDataA,
  input  logic [$clog2(NUM_REGS)-1:0] rdAddrB,
  output logic [DATA_W-1:0]           rdDataB,
  input  logic                        wrEn,
  input  logic [$clog2(NUM_REGS)-1:0] wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        userWe,
  input  logic [$clog2(NUM_REGS)-1:0] userAddr,
  input  logic [DATA_W-1:0]           userWrData,
  output logic [DATA_W-1:0]           userRdData,
  input  logic                        savedWrEn,
  input  logic [DATA_W-1:0]           savedWrData,
  output logic [DATA_W-1:0]           savedPsr,
  input  logic                        psrWrEn,
  input  logic [DATA_W-1:0]           psrWrData,
  output logic [DATA_W-1:0]           psr,
  output logic                        modeErr
);

  rfStrobe_t strobe;

  bankRfCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .psrWrEn   (psrWrEn),
    .psrWrData (psrWrData),
    .wrEn      (wrEn),
    .userWe    (userWe),
    .savedWrEn (savedWrEn),
    .psr       (psr),
    .modeErr   (modeErr),
    .strobe    (strobe)
  );

  bankRfData #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rdAddrA     (rdAddrA),
    .rdAddrB     (rdAddrB),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .userAddr    (userAddr),
    .userWrData  (userWrData),
    .savedWrData (savedWrData),
    .psrIn       (psr),
    .rdDataA     (rdDataA),
    .rdDataB     (rdDataB),
    .userRdData  (userRdData),
    .savedPsr    (savedPsr)
  );

endmodule

// File: rtl/bankedRegFileChk.sv
module bankedRegFileChk
  import bankRfPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [IDX_W-1:0]  rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [IDX_W-1:0]  userAddr,
  input logic [DATA_W-1:0] userRdData,
  input logic [DATA_W-1:0] savedPsr,
  input logic              psrWrEn,
  input logic [DATA_W-1:0] psrWrData,
  input logic [DATA_W-1:0] psr,
  input logic              modeErr
);

  // R5: a legal status write lands whole on the next cycle
  a_r5_psr_load: assert property (@(posedge clk) disable iff (!rstN)
    psrWrEn && modeValid(psrWrData[MODE_W-1:0]) |=> psr == $past(psrWrData));

  // R5: the active mode is always one of the seven encodings
  a_r5_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    modeValid(psr[MODE_W-1:0]));

  // R6: an illegal mode write leaves the status word and raises the error
  a_r6_bad_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    psrWrEn && !modeValid(psrWrData[MODE_W-1:0]) |=> $stable(psr) && modeErr);

  // R6: the error pulse follows only an illegal write
  a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !(psrWrEn && !modeValid(psrWrData[MODE_W-1:0])) |=> !modeErr);

  // R7: user and system modes mirror the status word on the saved output
  a_r7_saved_mirror: assert property (@(posedge clk) disable iff (!rstN)
    (psr[MODE_W-1:0] == MODE_USR || psr[MODE_W-1:0] == MODE_SYS) |-> savedPsr == psr);

  // R8: unbanked indices give the same value on the user-bank port
  a_r8_user_unbanked: assert property (@(posedge clk) disable iff (!rstN)
    (userAddr == rdAddrA) && (userAddr < IDX_W'(8) || userAddr == IDX_W'(15))
    |-> userRdData == rdDataA);

endmodule

bind bankedRegFile bankedRegFileChk #(.DATA_W(DATA_W), .IDX_W($clog2(NUM_REGS))) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .rdAddrA    (rdAddrA),
  .rdDataA    (rdDataA),
  .userAddr   (userAddr),
  .userRdData (userRdData),
  .savedPsr   (savedPsr),
  .psrWrEn    (psrWrEn),
  .psrWrData  (psrWrData),
  .psr        (psr),
  .modeErr    (modeErr)
);

// File: tb/sim_bankedRegFile.sv
`timescale 1ns/1ps
module sim_bankedRegFile;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0, userAddr = '0;
  logic [31:0] rdDataA, rdDataB, userRdData, savedPsr, psr;
  logic        wrEn = 1'b0, userWe = 1'b0, savedWrEn = 1'b0, psrWrEn = 1'b0;
  logic [31:0] wrData = '0, userWrData = '0, savedWrData = '0, psrWrData = '0;
  logic        modeErr;

  always #4 clk = ~clk;   // 125 MHz

  bankedRegFile u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // ---------------- reference model: live set plus swap on mode change
  logic [31:0] mR   [16];
  logic [31:0] mHi  [2][5];   // [0] non-fiq copy, [1] fiq copy
  logic [31:0] mBk  [6][2];   // r13/r14 per bank
  logic [31:0] mSv  [5];
  logic [31:0] mSpsr, mPsr;
  logic        mErr;
  int          cur, nxt;

  function automatic int mBank(input logic [4:0] m);
    case (m)
      5'b10011: return 1;
      5'b10111: return 2;
      5'b11011: return 3;
      5'b10010: return 4;
      5'b10001: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic bit mLegal(input logic [4:0] m);
    return m == 5'b10000 || m == 5'b10001 || m == 5'b10010 || m == 5'b10011 ||
           m == 5'b10111 || m == 5'b11011 || m == 5'b11111;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mR[i] = '0;
      for (int i = 0; i < 5; i++) begin mHi[0][i] = '0; mHi[1][i] = '0; mSv[i] = '0; end
      for (int i = 0; i < 6; i++) begin mBk[i][0] = '0; mBk[i][1] = '0; end
      mSpsr = '0; mPsr = 32'h1F; mErr = 1'b0;
    end else begin
      cur = mBank(mPsr[4:0]);
      if (userWe) begin
        if (userAddr >= 8 && userAddr <= 12 && cur == 5) mHi[0][userAddr-8] = userWrData;
        else if ((userAddr == 13 || userAddr == 14) && cur != 0) mBk[0][userAddr-13] = userWrData;
        else mR[userAddr] = userWrData;
      end
      if (wrEn) mR[wrAddr] = wrData;
      if (savedWrEn && cur != 0) mSpsr = savedWrData;
      mErr = 1'b0;
      if (psrWrEn) begin
        if (!mLegal(psrWrData[4:0])) mErr = 1'b1;
        else begin
          if (psrWrData[4:0] != mPsr[4:0]) begin
            nxt = mBank(psrWrData[4:0]);
            for (int i = 0; i < 5; i++) mHi[int'(cur == 5)][i] = mR[8+i];
            mBk[cur][0] = mR[13]; mBk[cur][1] = mR[14];
            if (cur != 0) mSv[cur-1] = mSpsr;
            for (int i = 0; i < 5; i++) mR[8+i] = mHi[int'(nxt == 5)][i];
            mR[13] = mBk[nxt][0]; mR[14] = mBk[nxt][1];
            if (nxt != 0) mSpsr = mSv[nxt-1];
          end
          mPsr = psrWrData;
        end
      end
    end
  end

  function automatic logic [31:0] expUser(input logic [3:0] a);
    int c = mBank(mPsr[4:0]);
    if (a >= 8 && a <= 12 && c == 5) return mHi[0][a-8];
    if ((a == 13 || a == 14) && c != 0) return mBk[0][a-13];
    return mR[a];
  endfunction

  function automatic string regReq(input logic [3:0] a);
    if (a >= 8 && a <= 12) return "R4";
    if (a == 13 || a == 14) return "R3";
    return "R2";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareReads();
    chk(regReq(rdAddrA), rdDataA, mR[rdAddrA]);
    chk(regReq(rdAddrB), rdDataB, mR[rdAddrB]);
    chk("R8", userRdData, expUser(userAddr));
  endtask

  task automatic compareAll();
    compareReads();
    chk("R5", psr, mPsr);
    chk("R7", savedPsr, (mBank(mPsr[4:0]) != 0) ? mSpsr : mPsr);
    chk("R6", {31'd0, modeErr}, {31'd0, mErr});
  endtask

  task automatic idle();
    wrEn = 0; userWe = 0; savedWrEn = 0; psrWrEn = 0;
  endtask

  task automatic cycle();
    @(posedge clk); @(negedge clk); compareAll(); idle();
  endtask

  task automatic sweep();
    for (int a = 0; a < 16; a++) begin
      rdAddrA = 4'(a); rdAddrB = 4'(15 - a); userAddr = 4'(a);
      #1; compareReads();
    end
  endtask

  task automatic setMode(input logic [4:0] m);
    psrWrEn = 1; psrWrData = {$urandom} & 32'hF800_00E0 | {27'd0, m};
    cycle();
  endtask

  logic [4:0] modes [7] = '{5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b10000, 5'b11111};

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", psr, 32'h1F);
    chk("R1", savedPsr, 32'h1F);
    chk("R1", {31'd0, modeErr}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      rdAddrA = 4'(a); userAddr = 4'(a); #1;
      chk("R1", rdDataA, 32'd0);
      chk("R1", userRdData, 32'd0);
    end
    rstN = 1;
    cycle();

    // fill every copy with a tag of mode and index (R2 R3 R4 R7)
    for (int m = 0; m < 7; m++) begin
      setMode(modes[m]);
      for (int a = 0; a < 16; a++) begin
        wrEn = 1; wrAddr = 4'(a); wrData = {8'hA0 | 8'(m), 16'h0, 8'(a)};
        cycle();
      end
      savedWrEn = 1; savedWrData = 32'h5A00_0000 | 32'(m);
      cycle();
    end
    for (int m = 0; m < 7; m++) begin
      setMode(modes[m]);
      sweep();
    end

    // R8: user-bank writes from fast-interrupt and supervisor modes
    setMode(5'b10001);
    userWe = 1; userAddr = 4'd9; userWrData = 32'hCAFE_0009; cycle();
    userWe = 1; userAddr = 4'd13; userWrData = 32'hCAFE_000D; cycle();
    sweep();
    setMode(5'b10011);
    userWe = 1; userAddr = 4'd14; userWrData = 32'hCAFE_000E; cycle();
    sweep();
    setMode(5'b11111); sweep();

    // R9: collision on one storage and on split copies
    wrEn = 1; wrAddr = 4'd3; wrData = 32'h1111_1111;
    userWe = 1; userAddr = 4'd3; userWrData = 32'h2222_2222;
    cycle();
    rdAddrA = 4'd3; #1; chk("R9", rdDataA, 32'h1111_1111);
    setMode(5'b10001);
    wrEn = 1; wrAddr = 4'd10; wrData = 32'h3333_3333;
    userWe = 1; userAddr = 4'd10; userWrData = 32'h4444_4444;
    cycle();
    rdAddrA = 4'd10; userAddr = 4'd10; #1;
    chk("R9", rdDataA, 32'h3333_3333);
    chk("R9", userRdData, 32'h4444_4444);

    // R10: no bypass, and writes at a mode-change edge use the old mode
    rdAddrA = 4'd5; #1;
    wrEn = 1; wrAddr = 4'd5; wrData = 32'h7777_0005; #1;
    chk("R10", rdDataA, mR[5]);
    cycle();
    chk("R10", rdDataA, 32'h7777_0005);
    wrEn = 1; wrAddr = 4'd13; wrData = 32'h8888_000D;
    savedWrEn = 1; savedWrData = 32'h8888_5555;
    psrWrEn = 1; psrWrData = 32'h0000_0013;
    cycle();
    setMode(5'b10001);
    rdAddrA = 4'd13; #1; chk("R10", rdDataA, 32'h8888_000D);
    chk("R10", savedPsr, 32'h8888_5555);

    // R6: illegal encodings
    foreach (modes[i]) begin end
    psrWrEn = 1; psrWrData = 32'hF000_0005; cycle();
    chk("R6", {31'd0, modeErr}, 32'd1);
    chk("R6", psr[4:0], 5'b10001);
    psrWrEn = 1; psrWrData = 32'h0000_0014; cycle();
    psrWrEn = 1; psrWrData = 32'h0000_001E; cycle();
    cycle();
    chk("R6", {31'd0, modeErr}, 32'd0);

    // R5: same-mode write changes flags only
    psrWrEn = 1; psrWrData = 32'hF000_0011; cycle();
    sweep();

    // random mix
    for (int n = 0; n < 6000; n++) begin
      rdAddrA = 4'($urandom); rdAddrB = 4'($urandom); userAddr = 4'($urandom);
      wrEn = ($urandom % 3) == 0; wrAddr = 4'($urandom); wrData = $urandom;
      userWe = ($urandom % 5) == 0; userWrData = $urandom;
      savedWrEn = ($urandom % 6) == 0; savedWrData = $urandom;
      psrWrEn = ($urandom % 7) == 0;
      psrWrData = ($urandom & 32'hF800_00E0) |
                  ((($urandom % 10) == 0) ? 32'($urandom % 32) : {27'd0, modes[$urandom % 7]});
      @(posedge clk); @(negedge clk); compareAll();
    end
    idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule